// File: doc/BRIEF.md
# Microprogram Sequencer with Bit-OR Branching

This block is the control unit of a single-bus processor, built around a microprogram. A micro-program counter selects a word from a control store that is built into the RTL. Each word holds encoded field groups: a bus-source group, a register-load group, an auxiliary load group, an ALU function, a memory command, an operand-select bit, a wait-for-memory bit and an end-of-instruction bit. A decoder expands these fields into one-hot bus-driver and load strobes for the datapath. Register codes can be redirected to the source or destination register number held in the instruction register.

The next-address logic handles sequencing. Every instruction starts with a shared fetch routine at addresses 0 to 2. Address 3 dispatches on the opcode. For the memory-operand add, the dispatch loads a base address and then ORs the addressing-mode bits of the instruction into the low bits of that address. The same idea is used later in the routine, where the instruction's direct bit is ORed into bit 0 so that a dereference step can be skipped. A branch-if-negative routine tests the N flag. While a word requests a wait and memory has not yet signalled completion, the counter and all strobes hold still. End returns the counter to 0.

Top module: `useq_ctrl`

## Requirements
- R1: During reset and after it, upc is 0. Word 0 drives PC onto the bus, loads MAR and Z, asserts mem_rd and sel_four, and sets alu_op to 0 (add). mem_wr stays low.
- R2: Fetch runs 0→1→2→3. Word 1 drives Z, loads PC and Y, and asserts wait_mfc. Word 2 drives MDR and loads IR.
- R3: While wait_mfc is 1 and mfc is 0, upc, drv_oh and ld_oh keep their values. The cycle after mfc is 1, the sequence moves on.
- R4: At address 3, opcode ir[15:11]=1 (memory add) gives next address octal 101, with bit5 |= ir[10], bit4 |= ir[9] and bit3 |= NOR(ir[10:8]).
- R5: At address 3, opcode 2 (branch if negative) gives octal 25. Any other opcode gives 0.
- R6: At octal 25, a flag_n of 0 gives next address 0. Otherwise, octal 26 drives the offset, sel_four=0, alu add, and loads Z. Octal 27 then drives Z, loads PC and asserts end_o.
- R7: Octal 123 and octal 101 wait for mfc and then go to octal 170 with bit 0 ORed with ir[8]. Octal 170 drives MDR, loads MAR, reads memory and waits.
- R8: Octal 121 drives register ir[7:4], loads MAR and Z, reads memory, and asserts sel_four. Octal 122 drives Z and loads register ir[7:4]. A register number of 4 or more selects no register strobe.
- R9: Octal 171 drives MDR and loads Y. Octal 172 drives register ir[3:0] with sel_four=0 and add, and loads Z. Octal 173 drives Z, loads register ir[3:0] and asserts end_o.
- R10: Octal 111 drives register ir[7:4], loads Y and jumps to octal 172. Octal 101 drives register ir[7:4], loads MAR, reads memory and asserts wait_mfc.
- R11: end_o (without a stall) gives next address 0. An address with no routine behind it carries end_o only.
- R12: drv_oh bits are PC 0, MDR 1, Z 2, R0..R3 3..6, TEMP 7, offset 8, with at most one set. ld_oh bits are PC 0, IR 1, Z 2, R0..R3 3..6, MAR 7, MDR 8, TEMP 9, Y 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| mfc | input | 1 | Memory operation completed |
| flag_n | input | 1 | Negative condition flag |
| upc | output | 7 | Current micro-program counter |
| drv_oh | output | 9 | One-hot bus driver strobes |
| ld_oh | output | 11 | Register load strobes |
| alu_op | output | 4 | ALU function code (0 add, 1 sub, 15 xor) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| sel_four | output | 1 | ALU A operand is constant 4 instead of Y |
| wait_mfc | output | 1 | Current word waits for mfc |
| end_o | output | 1 | Last word of an instruction |

## Verification
The memory-add opcode is swept over all eight mode/direct combinations, with every source and destination register from 0 to 3. This shows that each mode bit lands on its own dispatch address, and that the two register remaps select different strobes. The memory latency at the fetch wait and at the octal 123 wait is varied from 0 to 2 cycles, which separates a correct hold from early advancement. The branch-if-negative opcode is run with N at 0 and at 1 to show the skip and the taken path. Unknown opcodes and an out-of-range register number cover the paths that fall back to doing nothing.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
    parameter int UA_W = 7;
    parameter int IR_W = 16;
    localparam int NREG  = 4;
    localparam int RIX_W = 4;
    localparam int DRV_W = NREG + 5;
    localparam int LD_W  = NREG + 7;

    typedef logic [UA_W-1:0] uaddr_t;

    typedef enum logic [2:0] {
        BK_SEQ   = 3'd0,
        BK_DISP  = 3'd1,
        BK_IFNZ  = 3'd2,
        BK_ORIND = 3'd3,
        BK_JMP   = 3'd4
    } brk_e;

    // bus source codes
    localparam logic [3:0] S_NONE = 4'd0;
    localparam logic [3:0] S_PC   = 4'd1;
    localparam logic [3:0] S_MDR  = 4'd2;
    localparam logic [3:0] S_Z    = 4'd3;
    localparam logic [3:0] S_R0   = 4'd4;
    localparam logic [3:0] S_TMP  = 4'd8;
    localparam logic [3:0] S_OFF  = 4'd9;
    // primary load codes
    localparam logic [2:0] D_NONE = 3'd0;
    localparam logic [2:0] D_PC   = 3'd1;
    localparam logic [2:0] D_IR   = 3'd2;
    localparam logic [2:0] D_Z    = 3'd3;
    localparam logic [2:0] D_R0   = 3'd4;
    // auxiliary load codes
    localparam logic [2:0] X_NONE = 3'd0;
    localparam logic [2:0] X_MAR  = 3'd1;
    localparam logic [2:0] X_MDR  = 3'd2;
    localparam logic [2:0] X_TMP  = 3'd3;
    localparam logic [2:0] X_Y    = 3'd4;
    // alu and memory codes
    localparam logic [3:0] F_ADD  = 4'd0;
    localparam logic [3:0] F_SUB  = 4'd1;
    localparam logic [3:0] F_XOR  = 4'd15;
    localparam logic [1:0] M_NONE = 2'd0;
    localparam logic [1:0] M_RD   = 2'd1;
    localparam logic [1:0] M_WR   = 2'd2;
    // register remap
    localparam logic [1:0] RM_LIT = 2'd0;
    localparam logic [1:0] RM_SRC = 2'd1;
    localparam logic [1:0] RM_DST = 2'd2;
    // opcodes
    localparam logic [4:0] OP_ADDM = 5'd1;
    localparam logic [4:0] OP_BRN  = 5'd2;
    // fixed microaddresses
    localparam uaddr_t A_FETCH = 7'o000;
    localparam uaddr_t A_BRN   = 7'o025;
    localparam uaddr_t A_ADDM  = 7'o101;
    localparam uaddr_t A_DEREF = 7'o170;
    localparam uaddr_t A_SUM   = 7'o172;

    typedef struct packed {
        uaddr_t     tgt;
        brk_e       brk;
        logic [1:0] rmap;
        logic [3:0] src;
        logic [2:0] dst;
        logic [2:0] aux;
        logic [3:0] alu;
        logic [1:0] mem;
        logic       sel4;
        logic       wmfc;
        logic       fin;
    } uword_t;

    function automatic uword_t mk(input logic [3:0] s, input logic [2:0] d,
                                  input logic [2:0] a, input logic [3:0] f,
                                  input logic [1:0] m, input logic s4,
                                  input logic wt, input logic fn,
                                  input logic [1:0] rm, input brk_e bk,
                                  input uaddr_t t);
        uword_t w;
        w.tgt  = t;
        w.brk  = bk;
        w.rmap = rm;
        w.src  = s;
        w.dst  = d;
        w.aux  = a;
        w.alu  = f;
        w.mem  = m;
        w.sel4 = s4;
        w.wmfc = wt;
        w.fin  = fn;
        return w;
    endfunction
endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
    import useq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    always_comb begin
        // unprogrammed words only end the instruction
        word = mk(S_NONE, D_NONE, X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b1, RM_LIT, BK_SEQ, '0);
        case (addr)
            7'o000: word = mk(S_PC,   D_Z,    X_MAR,  F_ADD, M_RD,   1'b1, 1'b0, 1'b0, RM_LIT, BK_SEQ,   '0);
            7'o001: word = mk(S_Z,    D_PC,   X_Y,    F_ADD, M_NONE, 1'b0, 1'b1, 1'b0, RM_LIT, BK_SEQ,   '0);
            7'o002: word = mk(S_MDR,  D_IR,   X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_LIT, BK_SEQ,   '0);
            7'o003: word = mk(S_NONE, D_NONE, X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_LIT, BK_DISP,  '0);
            7'o025: word = mk(S_NONE, D_NONE, X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_LIT, BK_IFNZ,  A_FETCH);
            7'o026: word = mk(S_OFF,  D_Z,    X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_LIT, BK_SEQ,   '0);
            7'o027: word = mk(S_Z,    D_PC,   X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b1, RM_LIT, BK_SEQ,   '0);
            7'o101: word = mk(S_R0,   D_NONE, X_MAR,  F_ADD, M_RD,   1'b0, 1'b1, 1'b0, RM_SRC, BK_ORIND, A_DEREF);
            7'o111: word = mk(S_R0,   D_NONE, X_Y,    F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_SRC, BK_JMP,   A_SUM);
            7'o121: word = mk(S_R0,   D_Z,    X_MAR,  F_ADD, M_RD,   1'b1, 1'b0, 1'b0, RM_SRC, BK_SEQ,   '0);
            7'o122: word = mk(S_Z,    D_R0,   X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_SRC, BK_SEQ,   '0);
            7'o123: word = mk(S_NONE, D_NONE, X_NONE, F_ADD, M_NONE, 1'b0, 1'b1, 1'b0, RM_LIT, BK_ORIND, A_DEREF);
            7'o170: word = mk(S_MDR,  D_NONE, X_MAR,  F_ADD, M_RD,   1'b0, 1'b1, 1'b0, RM_LIT, BK_SEQ,   '0);
            7'o171: word = mk(S_MDR,  D_NONE, X_Y,    F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_LIT, BK_SEQ,   '0);
            7'o172: word = mk(S_R0,   D_Z,    X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b0, RM_DST, BK_SEQ,   '0);
            7'o173: word = mk(S_Z,    D_R0,   X_NONE, F_ADD, M_NONE, 1'b0, 1'b0, 1'b1, RM_DST, BK_SEQ,   '0);
            default: ;
        endcase
    end
endmodule

// File: rtl/useq_nextaddr.sv
`timescale 1ns/1ps
module useq_nextaddr
    import useq_pkg::*;
(
    input  uaddr_t     upc_q,
    input  brk_e       brk,
    input  uaddr_t     tgt,
    input  logic       wmfc,
    input  logic       fin,
    input  logic       mfc,
    input  logic       flag_n,
    input  logic [4:0] opcode,
    input  logic [2:0] mode,
    output uaddr_t     nxt
);
    uaddr_t disp_a;
    uaddr_t seq_a;

    always_comb begin
        disp_a = A_FETCH;
        case (opcode)
            OP_ADDM: begin
                disp_a    = A_ADDM;
                disp_a[5] = disp_a[5] | mode[2];
                disp_a[4] = disp_a[4] | mode[1];
                disp_a[3] = disp_a[3] | ~(|mode);
            end
            OP_BRN:  disp_a = A_BRN;
            default: disp_a = A_FETCH;
        endcase
    end

    always_comb begin
        seq_a = upc_q + uaddr_t'(1);
        if (wmfc && !mfc) begin
            nxt = upc_q;
        end else if (fin) begin
            nxt = A_FETCH;
        end else begin
            case (brk)
                BK_DISP:  nxt = disp_a;
                BK_IFNZ:  nxt = flag_n ? seq_a : tgt;
                BK_ORIND: nxt = tgt | uaddr_t'(mode[0]);
                BK_JMP:   nxt = tgt;
                default:  nxt = seq_a;
            endcase
        end
    end
endmodule

// File: rtl/useq_decode.sv
`timescale 1ns/1ps
module useq_decode
    import useq_pkg::*;
(
    input  logic [3:0]       src,
    input  logic [2:0]       dst,
    input  logic [2:0]       aux,
    input  logic [3:0]       alu,
    input  logic [1:0]       mem,
    input  logic [1:0]       rmap,
    input  logic             sel4,
    input  logic             wmfc,
    input  logic             fin,
    input  logic [RIX_W-1:0] rsrc,
    input  logic [RIX_W-1:0] rdst,
    output logic [DRV_W-1:0] drv_oh,
    output logic [LD_W-1:0]  ld_oh,
    output logic [3:0]       alu_op,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             sel_four,
    output logic             wait_mfc,
    output logic             end_o
);
    logic             src_is_reg;
    logic             dst_is_reg;
    logic [RIX_W-1:0] src_ix;
    logic [RIX_W-1:0] dst_ix;

    always_comb begin
        src_is_reg = (src[3:2] == 2'b01);
        dst_is_reg = dst[2];
        case (rmap)
            RM_SRC: begin src_ix = rsrc; dst_ix = rsrc; end
            RM_DST: begin src_ix = rdst; dst_ix = rdst; end
            default: begin
                src_ix = RIX_W'(src[1:0]);
                dst_ix = RIX_W'(dst[1:0]);
            end
        endcase
    end

    always_comb begin
        drv_oh[0]      = (src == S_PC);
        drv_oh[1]      = (src == S_MDR);
        drv_oh[2]      = (src == S_Z);
        drv_oh[NREG+3] = (src == S_TMP);
        drv_oh[NREG+4] = (src == S_OFF);
        ld_oh[0]       = (dst == D_PC);
        ld_oh[1]       = (dst == D_IR);
        ld_oh[2]       = (dst == D_Z);
        ld_oh[NREG+3]  = (aux == X_MAR);
        ld_oh[NREG+4]  = (aux == X_MDR);
        ld_oh[NREG+5]  = (aux == X_TMP);
        ld_oh[NREG+6]  = (aux == X_Y);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign drv_oh[3+g] = src_is_reg && (src_ix == RIX_W'(g));
        assign ld_oh[3+g]  = dst_is_reg && (dst_ix == RIX_W'(g));
    end

    assign alu_op   = alu;
    assign mem_rd   = (mem == M_RD);
    assign mem_wr   = (mem == M_WR);
    assign sel_four = sel4;
    assign wait_mfc = wmfc;
    assign end_o    = fin;
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IR_W-1:0]  ir,
    input  logic             mfc,
    input  logic             flag_n,
    output logic [UA_W-1:0]  upc,
    output logic [DRV_W-1:0] drv_oh,
    output logic [LD_W-1:0]  ld_oh,
    output logic [3:0]       alu_op,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             sel_four,
    output logic             wait_mfc,
    output logic             end_o
);
    typedef struct packed {
        uaddr_t upc;
    } seq_st_t;

    seq_st_t st_d, st_q;
    uword_t  cur_w;
    uaddr_t  nxt;

    useq_rom u_rom (
        .addr (st_q.upc),
        .word (cur_w)
    );

    useq_nextaddr u_nxt (
        .upc_q  (st_q.upc),
        .brk    (cur_w.brk),
        .tgt    (cur_w.tgt),
        .wmfc   (cur_w.wmfc),
        .fin    (cur_w.fin),
        .mfc    (mfc),
        .flag_n (flag_n),
        .opcode (ir[15:11]),
        .mode   (ir[10:8]),
        .nxt    (nxt)
    );

    useq_decode u_dec (
        .src      (cur_w.src),
        .dst      (cur_w.dst),
        .aux      (cur_w.aux),
        .alu      (cur_w.alu),
        .mem      (cur_w.mem),
        .rmap     (cur_w.rmap),
        .sel4     (cur_w.sel4),
        .wmfc     (cur_w.wmfc),
        .fin      (cur_w.fin),
        .rsrc     (ir[7:4]),
        .rdst     (ir[3:0]),
        .drv_oh   (drv_oh),
        .ld_oh    (ld_oh),
        .alu_op   (alu_op),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .sel_four (sel_four),
        .wait_mfc (wait_mfc),
        .end_o    (end_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upc = st_q.upc;

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mfc && !mfc) |=> ($stable(upc) && $stable(drv_oh) && $stable(ld_oh)));

    // R11
    end_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_o && !(wait_mfc && !mfc)) |=> (upc == A_FETCH));

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == A_FETCH) |=> (upc == uaddr_t'(1)));

    // R6
    brn_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == A_BRN && !flag_n) |=> (upc == A_FETCH));

    // R7
    deref_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 7'o123 && mfc) |=>
        (upc[UA_W-1:1] == A_DEREF[UA_W-1:1] && upc[0] == $past(ir[8])));

    // R12
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_oh));
endmodule

// File: tb/useq_ctrl_tb_top.sv
`timescale 1ns/1ps
module useq_ctrl_tb_top;
    localparam int DV_PC = 0, DV_MDR = 1, DV_Z = 2, DV_R0 = 3, DV_OFF = 8;
    localparam int LV_PC = 0, LV_IR = 1, LV_Z = 2, LV_R0 = 3, LV_MAR = 7, LV_Y = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ir = '0;
    logic        mfc = 1'b1;
    logic        flag_n = 1'b0;
    logic [6:0]  upc;
    logic [8:0]  drv_oh;
    logic [10:0] ld_oh;
    logic [3:0]  alu_op;
    logic        mem_rd, mem_wr, sel_four, wait_mfc, end_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    useq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ir(ir), .mfc(mfc), .flag_n(flag_n),
        .upc(upc), .drv_oh(drv_oh), .ld_oh(ld_oh), .alu_op(alu_op),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .sel_four(sel_four),
        .wait_mfc(wait_mfc), .end_o(end_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_disp(input logic [15:0] v);
        if (v[15:11] == 5'd1)
            return 65 + 32 * int'(v[10]) + 16 * int'(v[9])
                      + 8 * int'(!(v[10] || v[9] || v[8]));
        else if (v[15:11] == 5'd2)
            return 21;
        return 0;
    endfunction

    // fetch with lat cycles of memory delay at word 1; ends at dispatch target
    task automatic run_fetch(input logic [15:0] irv, input int lat);
        chk("R2 start at 0", int'(upc), 0);
        chk("R1 word0 drv", int'(drv_oh), 1 << DV_PC);
        chk("R1 word0 ld", int'(ld_oh), (1 << LV_MAR) | (1 << LV_Z));
        chk("R1 word0 rd/sel4", int'({mem_rd, sel_four}), 3);
        step();
        chk("R2 word1 upc", int'(upc), 1);
        chk("R2 word1 drv", int'(drv_oh), 1 << DV_Z);
        chk("R2 word1 ld", int'(ld_oh), (1 << LV_PC) | (1 << LV_Y));
        chk("R2 word1 wait", int'(wait_mfc), 1);
        mfc = 1'b0;
        for (int k = 0; k < lat; k++) begin
            step();
            chk("R3 hold at 1", int'(upc), 1);
            chk("R3 hold ld", int'(ld_oh), (1 << LV_PC) | (1 << LV_Y));
        end
        mfc = 1'b1;
        step();
        chk("R2 word2 upc", int'(upc), 2);
        chk("R2 word2 drv/ld", int'({drv_oh, ld_oh}), ((1 << DV_MDR) << 11) | (1 << LV_IR));
        ir = irv;
        step();
        chk("R2 word3 upc", int'(upc), 3);
        step();
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset upc", int'(upc), 0);
        chk("R1 reset alu/wr", int'({alu_op, mem_wr}), 0);
        chk("R1 reset drv", int'(drv_oh), 1 << DV_PC);
        rst_n = 1'b1;

        // memory add sweep over modes and registers
        for (int m = 0; m < 8; m++) begin
            for (int rs = 0; rs < 4; rs++) begin
                for (int rd = 0; rd < 4; rd++) begin
                    logic [15:0] v;
                    int lat;
                    int e;
                    lat = (m + rs + rd) % 3;
                    v = {5'd1, 3'(m), 2'b00, 2'(rs), 2'b00, 2'(rd)};
                    run_fetch(v, lat);
                    e = exp_disp(v);
                    chk("R4 dispatch", int'(upc), e);
                    if (m >= 4) begin
                        chk("R11 unprogrammed end", int'({end_o, drv_oh, ld_oh}), 1 << 20);
                        step();
                        chk("R11 back to 0", int'(upc), 0);
                        continue;
                    end
                    if (m == 0) begin
                        chk("R10 reg mode drv", int'(drv_oh), 1 << (DV_R0 + rs));
                        chk("R10 reg mode ld", int'(ld_oh), 1 << LV_Y);
                        step();
                        chk("R10 jump to 172", int'(upc), 8'o172);
                    end else begin
                        if (m == 1) begin
                            chk("R10 deferred drv", int'(drv_oh), 1 << (DV_R0 + rs));
                            chk("R10 deferred ld/rd/wait", int'({ld_oh, mem_rd, wait_mfc}),
                                ((1 << LV_MAR) << 2) | 3);
                        end else begin
                            chk("R8 w121 drv", int'(drv_oh), 1 << (DV_R0 + rs));
                            chk("R8 w121 ld", int'(ld_oh), (1 << LV_MAR) | (1 << LV_Z));
                            chk("R8 w121 rd/sel4", int'({mem_rd, sel_four}), 3);
                            step();
                            chk("R8 w122 drv", int'(drv_oh), 1 << DV_Z);
                            chk("R8 w122 ld", int'(ld_oh), 1 << (LV_R0 + rs));
                            step();
                            chk("R7 at 123", int'(upc), 8'o123);
                            chk("R7 123 waits", int'(wait_mfc), 1);
                        end
                        mfc = 1'b0;
                        for (int k = 0; k < lat; k++) begin
                            step();
                            chk("R3 hold at wait", int'(upc), (m == 1) ? 8'o101 : 8'o123);
                        end
                        mfc = 1'b1;
                        step();
                        chk("R7 deref branch", int'(upc), 8'o170 + (m & 1));
                        if ((m & 1) == 0) begin
                            chk("R7 w170 drv/ld", int'({drv_oh, ld_oh}), ((1 << DV_MDR) << 11) | (1 << LV_MAR));
                            chk("R7 w170 rd/wait", int'({mem_rd, wait_mfc}), 3);
                            step();
                        end
                        chk("R9 at 171", int'(upc), 8'o171);
                        chk("R9 w171 drv/ld", int'({drv_oh, ld_oh}), ((1 << DV_MDR) << 11) | (1 << LV_Y));
                        step();
                    end
                    chk("R9 w172 drv", int'(drv_oh), 1 << (DV_R0 + rd));
                    chk("R9 w172 ld/alu/sel4", int'({ld_oh, alu_op, sel_four}), (1 << LV_Z) << 5);
                    step();
                    chk("R9 w173 drv/ld", int'({drv_oh, ld_oh}), ((1 << DV_Z) << 11) | (1 << (LV_R0 + rd)));
                    chk("R9 w173 end", int'(end_o), 1);
                    step();
                    chk("R11 end to 0", int'(upc), 0);
                end
            end
        end

        // branch if negative, both flag values
        for (int nf = 0; nf < 2; nf++) begin
            flag_n = 1'(nf);
            run_fetch({5'd2, 11'h005}, nf);
            chk("R5 brn dispatch", int'(upc), 21);
            step();
            if (nf == 0) begin
                chk("R6 N=0 back to 0", int'(upc), 0);
            end else begin
                chk("R6 taken 26", int'(upc), 22);
                chk("R6 w26 drv", int'(drv_oh), 1 << DV_OFF);
                chk("R6 w26 ld/alu/sel4", int'({ld_oh, alu_op, sel_four}), (1 << LV_Z) << 5);
                step();
                chk("R6 w27 drv/ld/end", int'({drv_oh, ld_oh, end_o}), ((((1 << DV_Z) << 11) | (1 << LV_PC)) << 1) | 1);
                step();
                chk("R6 end to 0", int'(upc), 0);
            end
        end
        flag_n = 1'b0;

        // other opcodes fall back to fetch
        for (int op = 0; op < 32; op += 7) begin
            logic [15:0] v;
            v = {5'(op), 11'h3ff};
            run_fetch(v, 0);
            chk("R5 other opcode", int'(upc), exp_disp(v));
            if (upc != 0) begin
                step();
                step();
                step();
            end
        end

        // register number out of range selects no strobe
        run_fetch({5'd1, 3'b000, 4'd5, 4'd6}, 0);
        chk("R8 out-of-range src", int'(drv_oh), 0);
        step();
        chk("R8 out-of-range at 172", int'(drv_oh), 0);
        step();
        chk("R8 out-of-range ld", int'(ld_oh), 0);
        step();
        chk("R11 final return", int'(upc), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule